// File: doc/BRIEF.md
# Lane Alignment Sequence Receiver

This block watches one serial lane after 8b/10b decoding. Every clock it takes one decoded octet, a flag that says whether the octet is a control character, and a flag from the decoder that marks the octet as invalid. It first hunts for code-group synchronisation, which is a run of sync control characters. It then follows the four-multiframe initial lane alignment sequence. Each multiframe is MF_FRAMES frames of FRAME_OCTETS octets. The block checks the opening and closing marker of every multiframe. In the second multiframe it looks for the configuration delimiter and latches the ten link-parameter octets that follow it.

Once the closing marker of the fourth multiframe is accepted, the block raises a data-valid level. It also gives a one-cycle start pulse that lines up with the first user octet. A sequence violation gives a one-cycle error pulse and sends the block back to hunting. A sync request from the link layer, or a run of invalid octets, also sends it back to hunting, but without the error pulse. The latched parameters are compared with the expected values given as parameters, and a single match flag reports the result.

The controller has four states:
- `ST_HUNT`: waiting for synchronisation.
- `ST_CGS`: synchronised, with sync characters still arriving.
- `ST_ILA`: inside the alignment multiframes.
- `ST_DATA`: user data.

It has these transitions:
- HUNT→CGS: on the SYNC_RUN-th consecutive sync character.
- CGS→ILA: on an opening marker.
- ILA→DATA: on the closing marker of multiframe 3 (counting from 0).
- Any state→HUNT: on a sequence error, a sync request or an invalid-octet run.

Top module: `lane_align_rx`

## Requirements
- R1: While reset is active and right after it, not_synced is 1 and seq_error, data_valid, data_start and cfg_match are 0.
- R2: A sync character is octet 0xBC with the control flag set. not_synced falls after the SYNC_RUN-th consecutive one (default 4) has been clocked in. A run broken by any other octet starts the count again.
- R3: After synchronisation, further sync characters are accepted until an opening marker arrives. The opening marker is 0x1C with the control flag set. Four multiframes of MF_LEN = FRAME_OCTETS*MF_FRAMES octets (default 16) must follow. Position 0 of each holds 0x1C and position MF_LEN-1 holds the closing marker 0x7C, both with the control flag set. data_valid stays 0 until that closing marker of the fourth multiframe has been clocked in, and is 1 from then on.
- R4: data_start is 1 for exactly the one cycle in which the first user octet is presented. data_valid stays 1 while user octets of any value or control flag arrive, until a resynchronisation.
- R5: In the second multiframe, position 1 must be 0x9C with the control flag set. Anything else is a sequence error.
- R6: Positions 2 to 11 of the second multiframe are latched in order, so that octet i appears on cfg_octets[8i+7:8i]. The order is:
  - 0: device id
  - 1: adjust count[7:4] / bank id[3:0]
  - 2: adjust direction bit 6 / phase adjust bit 5 / lane id[4:0]
  - 3: scrambling bit 7 / lanes-1 [4:0]
  - 4: frame octets-1
  - 5: frames per multiframe-1 [4:0]
  - 6: converters-1
  - 7: control bits[7:6] / resolution-1 [4:0]
  - 8: subclass[7:5] / total bits-1 [4:0]
  - 9: version[7:5] / samples-1 [4:0]
- R7: Once all ten octets are latched, cfg_match is 1 exactly when every field of R6 equals its expected parameter. The bits not covered by a field are ignored: octet 2 bit 7, octet 3 bits 6:5, octet 5 bits 7:5 and octet 7 bit 5.
- R8: The block flags a sequence error in any of these cases:
  - a control character where filler or a parameter octet is expected;
  - a missing or early marker;
  - a non-sync octet between synchronisation and the first opening marker.
  On a sequence error, seq_error is 1 for the one following cycle and not_synced rises in that same cycle.
- R9: An active sync_request sets not_synced to 1 and data_valid to 0 in the next cycle, with no seq_error pulse.
- R10: BAD_RUN consecutive octets with rx_bad set (default 4) force the same restart as R9. A shorter run has no effect on data_valid.
- R11: cfg_match is 0 whenever not_synced is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_request | input | 1 | Link layer asks for resynchronisation |
| rx_octet | input | 8 | Decoded octet |
| rx_is_ctrl | input | 1 | Octet is a control character |
| rx_bad | input | 1 | Decoder flagged the octet invalid |
| not_synced | output | 1 | High while hunting for synchronisation |
| seq_error | output | 1 | One-cycle sequence error pulse |
| data_valid | output | 1 | User data phase |
| data_start | output | 1 | Pulse with the first user octet |
| cfg_match | output | 1 | Latched parameters equal expected values |
| cfg_octets | output | 80 | Latched parameter octets, octet i at [8i+7:8i] |

## Verification
A position counter that drifts by one octet shows up at once as a seq_error pulse. The drift makes a marker or the delimiter land on the wrong slot, so the pulse appears within one multiframe. A wrong capture index shows up as a cfg_octets value shifted by one octet, and cfg_match then drops as soon as the second multiframe ends. A state machine stuck or late in ILA is seen as data_valid or data_start missing on the exact octet after the fourth closing marker. A restart path that is wrong leaves not_synced low one cycle after a sync request or an invalid-octet run.

// File: rtl/la_pkg.sv
package la_pkg;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_CGS,
        ST_ILA,
        ST_DATA
    } la_state_t;

    localparam int CFG_OCTETS = 10;
    localparam int CFG_BITS   = 8 * CFG_OCTETS;

    // bits that carry a field, octet 9 on the left
    localparam logic [CFG_BITS-1:0] CFG_MASK = {
        8'hFF, 8'hFF, 8'hDF, 8'hFF, 8'h1F,
        8'hFF, 8'h9F, 8'h7F, 8'hFF, 8'hFF
    };

    function automatic logic [CFG_BITS-1:0] pack_cfg(
        input int did, input int adjcnt, input int bid,
        input int adjdir, input int phadj, input int lid,
        input int scr, input int lanes, input int fo, input int kf,
        input int conv, input int cs, input int nres, input int ntot,
        input int subc, input int ver, input int spf);
        logic [CFG_BITS-1:0] r;
        r[7:0]   = 8'(did);
        r[15:8]  = {4'(adjcnt), 4'(bid)};
        r[23:16] = {1'b0, 1'(adjdir), 1'(phadj), 5'(lid)};
        r[31:24] = {1'(scr), 2'b00, 5'(lanes - 1)};
        r[39:32] = 8'(fo - 1);
        r[47:40] = {3'b000, 5'(kf - 1)};
        r[55:48] = 8'(conv - 1);
        r[63:56] = {2'(cs), 1'b0, 5'(nres - 1)};
        r[71:64] = {3'(subc), 5'(ntot - 1)};
        r[79:72] = {3'(ver), 5'(spf - 1)};
        return r;
    endfunction

endpackage

// File: rtl/la_sync_mon.sv
module la_sync_mon #(
    parameter int          SYNC_RUN  = 4,
    parameter int          BAD_RUN   = 4,
    parameter logic [7:0]  SYNC_CHAR = 8'hBC
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] octet,
    input  logic       is_ctrl,
    input  logic       bad,
    output logic       is_sync,
    output logic       sync_hit,
    output logic       bad_hit
);
    localparam int SW = $clog2(SYNC_RUN + 1);
    localparam int BW = $clog2(BAD_RUN + 1);

    logic [SW-1:0] sync_cnt;
    logic [BW-1:0] bad_cnt;

    assign is_sync  = is_ctrl && (octet == SYNC_CHAR);
    assign sync_hit = is_sync && (int'(sync_cnt) >= SYNC_RUN - 1);
    assign bad_hit  = bad && (int'(bad_cnt) >= BAD_RUN - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_cnt <= '0;
            bad_cnt  <= '0;
        end else begin
            if (!is_sync)
                sync_cnt <= '0;
            else if (int'(sync_cnt) < SYNC_RUN)
                sync_cnt <= sync_cnt + SW'(1);

            if (!bad)
                bad_cnt <= '0;
            else if (int'(bad_cnt) < BAD_RUN)
                bad_cnt <= bad_cnt + BW'(1);
        end
    end
endmodule

// File: rtl/la_pos_cnt.sv
module la_pos_cnt #(
    parameter int MF_LEN = 16,
    localparam int POS_W = $clog2(MF_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             step,
    output logic [POS_W-1:0] pos,
    output logic [1:0]       mf
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
            mf  <= '0;
        end else if (start) begin
            pos <= POS_W'(1);
            mf  <= '0;
        end else if (step) begin
            if (pos == POS_W'(MF_LEN - 1)) begin
                pos <= '0;
                mf  <= mf + 2'd1;
            end else begin
                pos <= pos + POS_W'(1);
            end
        end
    end
endmodule

// File: rtl/la_cfg_store.sv
module la_cfg_store
    import la_pkg::*;
#(
    parameter logic [CFG_BITS-1:0] CFG_EXP = '0,
    localparam int IDX_W = $clog2(CFG_OCTETS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                cap_en,
    input  logic [IDX_W-1:0]    cap_idx,
    input  logic [7:0]          octet,
    output logic [CFG_BITS-1:0] cfg_octets,
    output logic                cfg_match
);
    logic                  done_q;
    logic [CFG_OCTETS-1:0] hit;

    for (genvar i = 0; i < CFG_OCTETS; i++) begin : g_oct
        logic [7:0] oct_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                oct_q <= '0;
            else if (cap_en && cap_idx == IDX_W'(i))
                oct_q <= octet;
        end
        assign cfg_octets[8*i +: 8] = oct_q;
        assign hit[i] = ((oct_q ^ CFG_EXP[8*i +: 8]) & CFG_MASK[8*i +: 8]) == 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            done_q <= 1'b0;
        else if (cap_en && cap_idx == IDX_W'(CFG_OCTETS - 1))
            done_q <= 1'b1;
    end

    assign cfg_match = done_q && (&hit);
endmodule

// File: rtl/lane_align_rx.sv
module lane_align_rx
    import la_pkg::*;
#(
    parameter int         FRAME_OCTETS = 2,
    parameter int         MF_FRAMES    = 8,
    parameter int         SYNC_RUN     = 4,
    parameter int         BAD_RUN      = 4,
    parameter logic [7:0] SYNC_CHAR    = 8'hBC,
    parameter logic [7:0] START_CHAR   = 8'h1C,
    parameter logic [7:0] END_CHAR     = 8'h7C,
    parameter logic [7:0] CFG_CHAR     = 8'h9C,
    parameter int         EXP_DID      = 8'h5A,
    parameter int         EXP_ADJCNT   = 0,
    parameter int         EXP_BID      = 3,
    parameter int         EXP_ADJDIR   = 0,
    parameter int         EXP_PHADJ    = 0,
    parameter int         EXP_LID      = 2,
    parameter int         EXP_SCR      = 0,
    parameter int         EXP_LANES    = 2,
    parameter int         EXP_CONV     = 4,
    parameter int         EXP_CS       = 2,
    parameter int         EXP_NRES     = 14,
    parameter int         EXP_NTOT     = 16,
    parameter int         EXP_SUBCLASS = 1,
    parameter int         EXP_VERSION  = 1,
    parameter int         EXP_SPF      = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_request,
    input  logic [7:0]    rx_octet,
    input  logic          rx_is_ctrl,
    input  logic          rx_bad,
    output logic          not_synced,
    output logic          seq_error,
    output logic          data_valid,
    output logic          data_start,
    output logic          cfg_match,
    output logic [79:0]   cfg_octets
);
    localparam int MF_LEN = FRAME_OCTETS * MF_FRAMES;
    localparam int POS_W  = $clog2(MF_LEN);
    localparam int IDX_W  = $clog2(CFG_OCTETS);
    localparam logic [CFG_BITS-1:0] CFG_EXP = pack_cfg(
        EXP_DID, EXP_ADJCNT, EXP_BID, EXP_ADJDIR, EXP_PHADJ, EXP_LID,
        EXP_SCR, EXP_LANES, FRAME_OCTETS, MF_FRAMES, EXP_CONV, EXP_CS,
        EXP_NRES, EXP_NTOT, EXP_SUBCLASS, EXP_VERSION, EXP_SPF);

    la_state_t         st_q, st_d;
    logic              is_sync, sync_hit, bad_hit;
    logic              is_start, is_end, is_cfg;
    logic              err, restart, start_ila, step, cap_en;
    logic [POS_W-1:0]  pos;
    logic [1:0]        mf;
    logic [IDX_W-1:0]  cap_idx;
    logic              err_q, begun_q;

    assign is_start = rx_is_ctrl && (rx_octet == START_CHAR);
    assign is_end   = rx_is_ctrl && (rx_octet == END_CHAR);
    assign is_cfg   = rx_is_ctrl && (rx_octet == CFG_CHAR);
    assign cap_idx  = IDX_W'(pos - POS_W'(2));

    la_sync_mon #(
        .SYNC_RUN  (SYNC_RUN),
        .BAD_RUN   (BAD_RUN),
        .SYNC_CHAR (SYNC_CHAR)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .octet    (rx_octet),
        .is_ctrl  (rx_is_ctrl),
        .bad      (rx_bad),
        .is_sync  (is_sync),
        .sync_hit (sync_hit),
        .bad_hit  (bad_hit)
    );

    la_pos_cnt #(
        .MF_LEN (MF_LEN)
    ) u_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_ila),
        .step  (step),
        .pos   (pos),
        .mf    (mf)
    );

    la_cfg_store #(
        .CFG_EXP (CFG_EXP)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (restart),
        .cap_en     (cap_en),
        .cap_idx    (cap_idx),
        .octet      (rx_octet),
        .cfg_octets (cfg_octets),
        .cfg_match  (cfg_match)
    );

    // next state and sequence checks
    always_comb begin
        st_d      = st_q;
        err       = 1'b0;
        start_ila = 1'b0;
        step      = 1'b0;
        cap_en    = 1'b0;
        if (sync_request || bad_hit) begin
            st_d = ST_HUNT;
        end else begin
            unique case (st_q)
                ST_HUNT: begin
                    if (sync_hit)
                        st_d = ST_CGS;
                end
                ST_CGS: begin
                    if (is_start) begin
                        st_d      = ST_ILA;
                        start_ila = 1'b1;
                    end else if (!is_sync) begin
                        err = 1'b1;
                    end
                end
                ST_ILA: begin
                    step = 1'b1;
                    if (pos == POS_W'(MF_LEN - 1)) begin
                        if (!is_end)
                            err = 1'b1;
                        else if (mf == 2'd3)
                            st_d = ST_DATA;
                    end else if (pos == '0) begin
                        if (!is_start)
                            err = 1'b1;
                    end else if (mf == 2'd1 && pos == POS_W'(1)) begin
                        if (!is_cfg)
                            err = 1'b1;
                    end else begin
                        if (rx_is_ctrl)
                            err = 1'b1;
                        else if (mf == 2'd1 && pos < POS_W'(CFG_OCTETS + 2))
                            cap_en = 1'b1;
                    end
                end
                ST_DATA: begin
                    st_d = ST_DATA;
                end
            endcase
            if (err)
                st_d = ST_HUNT;
        end
    end

    assign restart = (st_d == ST_HUNT) && (st_q != ST_HUNT || sync_request || bad_hit);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_HUNT;
            err_q   <= 1'b0;
            begun_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            err_q   <= err;
            begun_q <= (st_q == ST_DATA);
        end
    end

    // outputs
    always_comb begin
        not_synced = (st_q == ST_HUNT);
        data_valid = (st_q == ST_DATA);
        data_start = (st_q == ST_DATA) && !begun_q;
        seq_error  = err_q;
    end
endmodule

// File: rtl/la_rx_chk.sv
module la_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic sync_request,
    input logic not_synced,
    input logic seq_error,
    input logic data_valid,
    input logic data_start,
    input logic cfg_match
);
    // R4
    start_in_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_start |-> data_valid);
    // R4
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_start |=> !data_start);
    // R4
    valid_opens_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_valid) |-> data_start);
    // R8
    error_resyncs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_error |-> not_synced);
    // R9
    request_resyncs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_request |=> (not_synced && !seq_error));
    // R11
    match_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        not_synced |-> !cfg_match);
    // R10
    valid_ends_in_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_valid) |-> not_synced);
endmodule

bind lane_align_rx la_rx_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_request (sync_request),
    .not_synced   (not_synced),
    .seq_error    (seq_error),
    .data_valid   (data_valid),
    .data_start   (data_start),
    .cfg_match    (cfg_match)
);

// File: tb/sim_lane_align_rx.sv
`timescale 1ns/1ps
module sim_lane_align_rx;
    localparam int MF_LEN = 16;
    localparam logic [79:0] GOOD_CFG = {8'h20, 8'h2F, 8'h8D, 8'h03, 8'h07,
                                        8'h01, 8'h01, 8'h02, 8'h03, 8'h5A};
    localparam logic [79:0] FIELD_BITS = {8'hFF, 8'hFF, 8'hDF, 8'hFF, 8'h1F,
                                          8'hFF, 8'h9F, 8'h7F, 8'hFF, 8'hFF};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_request = 1'b0;
    logic [7:0]  rx_octet = 8'h00;
    logic        rx_is_ctrl = 1'b0;
    logic        rx_bad = 1'b0;
    logic        not_synced, seq_error, data_valid, data_start, cfg_match;
    logic [79:0] cfg_octets;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lane_align_rx u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_request (sync_request),
        .rx_octet     (rx_octet),
        .rx_is_ctrl   (rx_is_ctrl),
        .rx_bad       (rx_bad),
        .not_synced   (not_synced),
        .seq_error    (seq_error),
        .data_valid   (data_valid),
        .data_start   (data_start),
        .cfg_match    (cfg_match),
        .cfg_octets   (cfg_octets)
    );

    task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] o, input bit c, input bit b);
        @(negedge clk);
        rx_octet = o; rx_is_ctrl = c; rx_bad = b;
        @(posedge clk);
        #1;
    endtask

    task automatic syncs(input int n);
        for (int i = 0; i < n; i++) send(8'hBC, 1'b1, 1'b0);
    endtask

    task automatic pulse_req();
        @(negedge clk);
        sync_request = 1'b1; rx_octet = 8'h00; rx_is_ctrl = 1'b0; rx_bad = 1'b0;
        @(posedge clk);
        #1;
        chk(not_synced == 1'b1, "R9 not_synced", 80'(not_synced), 80'd1);
        chk(data_valid == 1'b0 && seq_error == 1'b0, "R9 valid/error",
            80'({data_valid, seq_error}), 80'd0);
        @(negedge clk);
        sync_request = 1'b0;
    endtask

    // full alignment sequence; inj_mf < 0 means no injected octet
    task automatic run_ilas(input logic [79:0] cfg, input int inj_mf, input int inj_pos,
                            input logic [7:0] inj_o, input bit inj_c);
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < MF_LEN; p++) begin
                logic [7:0] o;
                bit c;
                if (p == 0) begin o = 8'h1C; c = 1'b1; end
                else if (p == MF_LEN - 1) begin o = 8'h7C; c = 1'b1; end
                else if (m == 1 && p == 1) begin o = 8'h9C; c = 1'b1; end
                else if (m == 1 && p < 12) begin o = cfg[8*(p-2) +: 8]; c = 1'b0; end
                else begin o = 8'($urandom); c = 1'b0; end
                if (m == inj_mf && p == inj_pos) begin
                    send(inj_o, inj_c, 1'b0);
                    return;
                end
                send(o, c, 1'b0);
            end
        end
    endtask

    function automatic bit exp_match(input logic [79:0] cfg);
        return ((cfg ^ GOOD_CFG) & FIELD_BITS) == 80'd0;
    endfunction

    task automatic err_case(input int m, input int p, input logic [7:0] o, input bit c, input string req);
        pulse_req();
        syncs(4);
        run_ilas(GOOD_CFG, m, p, o, c);
        chk(seq_error == 1'b1 && not_synced == 1'b1, req, 80'({seq_error, not_synced}), 80'd3);
        chk(cfg_match == 1'b0, "R11 match cleared", 80'(cfg_match), 80'd0);
        send(8'hBC, 1'b1, 1'b0);
        chk(seq_error == 1'b0, {req, " pulse width"}, 80'(seq_error), 80'd0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        #1;
        chk(not_synced == 1'b1, "R1 reset not_synced", 80'(not_synced), 80'd1);
        chk({seq_error, data_valid, data_start, cfg_match} == 4'b0, "R1 reset outputs",
            80'({seq_error, data_valid, data_start, cfg_match}), 80'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(not_synced == 1'b1 && data_valid == 1'b0, "R1 after reset",
            80'({not_synced, data_valid}), 80'd2);

        // R2: interrupted run, then a full run
        syncs(3);
        chk(not_synced == 1'b1, "R2 short run", 80'(not_synced), 80'd1);
        send(8'h00, 1'b0, 1'b0);
        syncs(3);
        chk(not_synced == 1'b1, "R2 broken run", 80'(not_synced), 80'd1);
        syncs(1);
        chk(not_synced == 1'b0, "R2 locked", 80'(not_synced), 80'd0);
        syncs(2);

        // R3: data_valid only after the last closing marker
        run_ilas(GOOD_CFG, 3, MF_LEN - 2, 8'h00, 1'b0);
        chk(data_valid == 1'b0 && seq_error == 1'b0 && not_synced == 1'b0, "R3 before end",
            80'({data_valid, seq_error, not_synced}), 80'd0);
        send(8'h7C, 1'b1, 1'b0);
        chk(data_valid == 1'b1, "R3 data after fourth end", 80'(data_valid), 80'd1);
        chk(data_start == 1'b1, "R4 start pulse", 80'(data_start), 80'd1);
        chk(cfg_octets == GOOD_CFG, "R6 captured octets", cfg_octets, GOOD_CFG);
        chk(cfg_match == 1'b1, "R7 exact match", 80'(cfg_match), 80'd1);
        send(8'h3A, 1'b0, 1'b0);
        chk(data_start == 1'b0 && data_valid == 1'b1, "R4 after first octet",
            80'({data_start, data_valid}), 80'd1);

        // random trials
        for (int t = 0; t < 10; t++) begin
            logic [79:0] cfg;
            int nuser;
            pulse_req();
            syncs(4 + int'($urandom % 6));
            cfg = GOOD_CFG;
            if ($urandom % 3 != 0) cfg[$urandom % 80] ^= 1'b1;
            run_ilas(cfg, -1, 0, 8'h00, 1'b0);
            chk(cfg_octets == cfg, "R6 random capture", cfg_octets, cfg);
            chk(cfg_match == exp_match(cfg), "R7 random compare", 80'(cfg_match), 80'(exp_match(cfg)));
            chk(data_valid == 1'b1 && data_start == 1'b1, "R3 random entry",
                80'({data_valid, data_start}), 80'd3);
            nuser = 3 + int'($urandom % 10);
            for (int u = 0; u < nuser; u++) begin
                send(8'($urandom), 1'($urandom), 1'b0);
                chk(data_valid == 1'b1 && data_start == 1'b0, "R4 data held",
                    80'({data_valid, data_start}), 80'd2);
            end
        end

        // sequence errors
        err_case(1, 1, 8'h00, 1'b0, "R5 missing delimiter");
        err_case(0, 5, 8'h7C, 1'b1, "R8 early end marker");
        err_case(2, 7, 8'hBC, 1'b1, "R8 control in filler");
        err_case(2, 0, 8'h55, 1'b0, "R8 missing start");
        err_case(0, MF_LEN - 1, 8'h11, 1'b0, "R8 missing end");
        pulse_req();
        syncs(4);
        send(8'h42, 1'b0, 1'b0);
        chk(seq_error == 1'b1 && not_synced == 1'b1, "R8 filler before start",
            80'({seq_error, not_synced}), 80'd3);

        // R10: invalid-octet runs
        pulse_req();
        syncs(4);
        run_ilas(GOOD_CFG, -1, 0, 8'h00, 1'b0);
        for (int i = 0; i < 3; i++) send(8'h00, 1'b0, 1'b1);
        chk(data_valid == 1'b1, "R10 short bad run", 80'(data_valid), 80'd1);
        send(8'h00, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) send(8'h00, 1'b0, 1'b1);
        chk(data_valid == 1'b1, "R10 broken bad run", 80'(data_valid), 80'd1);
        send(8'h00, 1'b0, 1'b1);
        chk(not_synced == 1'b1 && data_valid == 1'b0 && seq_error == 1'b0, "R10 full bad run",
            80'({not_synced, data_valid, seq_error}), 80'd4);
        chk(cfg_match == 1'b0, "R11 match after bad run", 80'(cfg_match), 80'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule